// File: doc/BRIEF.md
# Time-Multiplexed Leaky Integrate-and-Fire Neuron With Adaptive Threshold

This block evaluates a small population of virtual neurons on one shared datapath. Each virtual neuron has four 16-bit signed state words: a membrane potential, an excitatory conductance, an inhibitory conductance and a homeostatic threshold offset (theta). A one-cycle `step_start` pulse starts a time step. The unit then visits the neurons in index order, one per clock. In each slot it leaks the potential toward rest, integrates a scaled sum of both conductances, compares the result against the base threshold plus theta, and writes the new state back.

Synaptic events arrive on a separate port and can come at any time. Each event carries a neuron index, a type flag and a signed weight. The weight goes into one conductance of the addressed neuron. Both conductances decay by a right-shift fraction once per step.

When a neuron fires, its potential returns to rest and, if homeostasis is on for that neuron, theta grows by a fixed increment. Theta decays only on every DECIM-th step. At 16-bit resolution a per-step fraction of a slow time constant would round to zero, so spacing the decay out keeps a long time constant visible. Every state update saturates at the signed 16-bit limits instead of wrapping.

Top module: `lif_neuron_unit`

## Requirements
- R1: After reset every potential equals VREST, and all conductances and all theta values are zero. While no slot result is presented, `eval_valid`, `spike_valid`, `eval_vmem` and `eval_theta` are zero.
- R2: A `step_start` pulse that is sampled while the unit is idle produces NUM_VN consecutive cycles of `eval_valid`, with `eval_idx` going 0, 1, … NUM_VN-1. The first of these cycles follows the clock edge that ends slot 0. A `step_start` that arrives while a step is in progress is ignored.
- R3: A `syn_valid` event adds `syn_weight` to the addressed neuron's conductance, with saturation. `syn_inh`=0 selects the excitatory conductance and `syn_inh`=1 the inhibitory one. In each evaluation, the excitatory conductance becomes g − (g >>> GEX_SHIFT) and the inhibitory conductance becomes g − (g >>> GIH_SHIFT), using arithmetic shifts.
- R4: In each evaluation the integrated potential is v + ((VREST − v) >>> TAU_M_SHIFT) + ((K_MUL·(gex + gih)) >>> CUR_SHIFT). It is computed from the conductances held before this step's decay and is saturated.
- R5: If the integrated potential is greater than or equal to VTH + theta, the neuron spikes. `spike_valid` is high in that neuron's result cycle, `spike_idx` equals its index, and the reported and stored potential is VREST.
- R6: A spike on a neuron whose `homeo_en` bit is 1 raises its theta by DTHETA, with saturation. The raise applies after any decay in the same step.
- R7: Steps are counted from zero after reset. In a step whose count modulo DECIM equals DECIM−1, theta becomes theta − (theta >>> THETA_SHIFT) before the threshold comparison. In all other steps theta does not decay.
- R8: For a neuron whose `homeo_en` bit is 0, theta neither grows nor decays, but its stored value still adds to the threshold.
- R9: The potential, both conductances and theta saturate at +32767 and −32768.
- R10: An event that addresses the neuron currently in its evaluation slot is added to that neuron's freshly decayed conductance and is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_start | input | 1 | Starts one time step when idle |
| homeo_en | input | NUM_VN | Per-neuron homeostasis enable |
| syn_valid | input | 1 | Synaptic event strobe |
| syn_idx | input | IW | Target virtual neuron |
| syn_inh | input | 1 | 0 excitatory, 1 inhibitory conductance |
| syn_weight | input | 16 | Signed event weight |
| spike_valid | output | 1 | Spike in the presented slot |
| spike_idx | output | IW | Index of the spiking neuron |
| eval_valid | output | 1 | A slot result is presented |
| eval_idx | output | IW | Neuron index of the presented result |
| eval_vmem | output | 16 | New potential of that neuron |
| eval_theta | output | 16 | New theta of that neuron |

## Verification
The assertions take for granted that `homeo_en` stays stable during a step, that DTHETA is non-negative (so theta can never turn negative), and that reset is applied before the first step. Under these conditions the result slots appear strictly in index order and every spike is tagged with its own slot and reported at rest.

The bench respects these conditions. It changes `homeo_en` only between steps. During a step it sends events only to the neuron currently in its slot, so the reference model can apply every event at a well-defined point. Deliberately extreme weights push the conductances and the potential into both saturation rails.

// File: rtl/lif_pkg.sv
package lif_pkg;

    localparam int DATA_W = 16;
    localparam int ACC_W  = 2 * DATA_W + 2;

    typedef logic signed [DATA_W-1:0] data_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam acc_t DATA_MAX = acc_t'(2 ** (DATA_W - 1) - 1);
    localparam acc_t DATA_MIN = -acc_t'(2 ** (DATA_W - 1));

    typedef struct packed {
        data_t vmem;
        data_t gex;
        data_t gih;
        data_t theta;
    } nrn_state_t;

    // Clamp a wide signed intermediate into the state word range.
    function automatic data_t sat_data(input acc_t x);
        if (x > DATA_MAX) begin
            return data_t'(DATA_MAX);
        end else if (x < DATA_MIN) begin
            return data_t'(DATA_MIN);
        end
        return data_t'(x);
    endfunction

endpackage

// File: rtl/lif_seq.sv
module lif_seq #(
    parameter int NUM_VN = 8,
    parameter int DECIM  = 64,
    localparam int IW    = (NUM_VN > 1) ? $clog2(NUM_VN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_start,
    output logic          busy,
    output logic [IW-1:0] slot_idx,
    output logic          decay_step
);

    localparam int CW = (DECIM > 1) ? $clog2(DECIM) : 1;
    localparam logic [IW-1:0] LAST_SLOT = IW'(NUM_VN - 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(DECIM - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [CW-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (step_start) begin
                seq_d.busy = 1'b1;
                seq_d.idx  = '0;
            end
        end else if (seq_q.idx == LAST_SLOT) begin
            seq_d.busy = 1'b0;
            seq_d.idx  = '0;
            seq_d.step = (seq_q.step == LAST_STEP) ? '0 : CW'(seq_q.step + 1'b1);
        end else begin
            seq_d.idx = IW'(seq_q.idx + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy       = seq_q.busy;
    assign slot_idx   = seq_q.idx;
    assign decay_step = (seq_q.step == LAST_STEP);

endmodule

// File: rtl/lif_core.sv
module lif_core
    import lif_pkg::*;
#(
    parameter int VREST       = -6500,
    parameter int VTH         = -5000,
    parameter int K_MUL       = 1,
    parameter int CUR_SHIFT   = 2,
    parameter int TAU_M_SHIFT = 3,
    parameter int GEX_SHIFT   = 2,
    parameter int GIH_SHIFT   = 1,
    parameter int DTHETA      = 200,
    parameter int THETA_SHIFT = 4
) (
    input  nrn_state_t cur,
    input  logic       decay_step,
    input  logic       homeo_on,
    output nrn_state_t nxt,
    output logic       spike
);

    acc_t  v_a;
    acc_t  leak_a;
    acc_t  drive_a;
    acc_t  gex_a;
    acc_t  gih_a;
    acc_t  th_a;
    data_t v_int;
    data_t th_dec;
    data_t thr;

    always_comb begin
        v_a     = acc_t'($signed(cur.vmem));
        gex_a   = acc_t'($signed(cur.gex));
        gih_a   = acc_t'($signed(cur.gih));
        th_a    = acc_t'($signed(cur.theta));

        // Leak toward rest and integrate the summed conductances.
        leak_a  = (acc_t'(VREST) - v_a) >>> TAU_M_SHIFT;
        drive_a = (acc_t'(K_MUL) * (gex_a + gih_a)) >>> CUR_SHIFT;
        v_int   = sat_data(v_a + leak_a + drive_a);

        // Undersampled theta decay, only with homeostasis active.
        if (decay_step && homeo_on) begin
            th_dec = sat_data(th_a - (th_a >>> THETA_SHIFT));
        end else begin
            th_dec = cur.theta;
        end

        thr   = sat_data(acc_t'(VTH) + acc_t'($signed(th_dec)));
        spike = (v_int >= thr);

        nxt.vmem = spike ? data_t'(VREST) : v_int;
        if (spike && homeo_on) begin
            nxt.theta = sat_data(acc_t'($signed(th_dec)) + acc_t'(DTHETA));
        end else begin
            nxt.theta = th_dec;
        end
        nxt.gex = sat_data(gex_a - (gex_a >>> GEX_SHIFT));
        nxt.gih = sat_data(gih_a - (gih_a >>> GIH_SHIFT));
    end

endmodule

// File: rtl/lif_bank.sv
module lif_bank
    import lif_pkg::*;
#(
    parameter int NUM_VN     = 8,
    parameter int RESET_VMEM = -6500,
    localparam int IW        = (NUM_VN > 1) ? $clog2(NUM_VN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output nrn_state_t    rd_state,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  nrn_state_t    wr_state,
    input  logic          ev_valid,
    input  logic [IW-1:0] ev_idx,
    input  logic          ev_inh,
    input  data_t         ev_weight
);

    nrn_state_t bank_d [NUM_VN];
    nrn_state_t bank_q [NUM_VN];

    always_comb begin
        for (int e = 0; e < NUM_VN; e++) begin
            if (wr_en && (wr_idx == IW'(e))) begin
                bank_d[e] = wr_state;
            end else begin
                bank_d[e] = bank_q[e];
            end
            // An event lands on top of the slot write-back of the same entry.
            if (ev_valid && (ev_idx == IW'(e))) begin
                if (ev_inh) begin
                    bank_d[e].gih = sat_data(acc_t'($signed(bank_d[e].gih))
                                             + acc_t'($signed(ev_weight)));
                end else begin
                    bank_d[e].gex = sat_data(acc_t'($signed(bank_d[e].gex))
                                             + acc_t'($signed(ev_weight)));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_VN; e++) begin
                bank_q[e].vmem  <= data_t'(RESET_VMEM);
                bank_q[e].gex   <= '0;
                bank_q[e].gih   <= '0;
                bank_q[e].theta <= '0;
            end
        end else begin
            for (int e = 0; e < NUM_VN; e++) begin
                bank_q[e] <= bank_d[e];
            end
        end
    end

    assign rd_state = bank_q[rd_idx];

endmodule

// File: rtl/lif_neuron_unit.sv
module lif_neuron_unit
    import lif_pkg::*;
#(
    parameter int NUM_VN      = 8,
    parameter int VREST       = -6500,
    parameter int VTH         = -5000,
    parameter int K_MUL       = 1,
    parameter int CUR_SHIFT   = 2,
    parameter int TAU_M_SHIFT = 3,
    parameter int GEX_SHIFT   = 2,
    parameter int GIH_SHIFT   = 1,
    parameter int DTHETA      = 200,
    parameter int THETA_SHIFT = 4,
    parameter int DECIM       = 64,
    localparam int IW         = (NUM_VN > 1) ? $clog2(NUM_VN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_start,
    input  logic [NUM_VN-1:0] homeo_en,
    input  logic              syn_valid,
    input  logic [IW-1:0]     syn_idx,
    input  logic              syn_inh,
    input  logic [15:0]       syn_weight,
    output logic              spike_valid,
    output logic [IW-1:0]     spike_idx,
    output logic              eval_valid,
    output logic [IW-1:0]     eval_idx,
    output logic [15:0]       eval_vmem,
    output logic [15:0]       eval_theta
);

    typedef struct packed {
        logic          valid;
        logic [IW-1:0] idx;
        logic          spike;
        data_t         vmem;
        data_t         theta;
    } out_t;

    logic          busy;
    logic [IW-1:0] slot_idx;
    logic          decay_step;
    nrn_state_t    cur_state;
    nrn_state_t    nxt_state;
    logic          spike_c;
    out_t          out_d, out_q;

    lif_seq #(
        .NUM_VN (NUM_VN),
        .DECIM  (DECIM)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_start (step_start),
        .busy       (busy),
        .slot_idx   (slot_idx),
        .decay_step (decay_step)
    );

    lif_bank #(
        .NUM_VN     (NUM_VN),
        .RESET_VMEM (VREST)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (slot_idx),
        .rd_state  (cur_state),
        .wr_en     (busy),
        .wr_idx    (slot_idx),
        .wr_state  (nxt_state),
        .ev_valid  (syn_valid),
        .ev_idx    (syn_idx),
        .ev_inh    (syn_inh),
        .ev_weight (data_t'(syn_weight))
    );

    lif_core #(
        .VREST       (VREST),
        .VTH         (VTH),
        .K_MUL       (K_MUL),
        .CUR_SHIFT   (CUR_SHIFT),
        .TAU_M_SHIFT (TAU_M_SHIFT),
        .GEX_SHIFT   (GEX_SHIFT),
        .GIH_SHIFT   (GIH_SHIFT),
        .DTHETA      (DTHETA),
        .THETA_SHIFT (THETA_SHIFT)
    ) u_core (
        .cur        (cur_state),
        .decay_step (decay_step),
        .homeo_on   (homeo_en[slot_idx]),
        .nxt        (nxt_state),
        .spike      (spike_c)
    );

    always_comb begin
        out_d = '0;
        if (busy) begin
            out_d.valid = 1'b1;
            out_d.idx   = slot_idx;
            out_d.spike = spike_c;
            out_d.vmem  = nxt_state.vmem;
            out_d.theta = nxt_state.theta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign eval_valid  = out_q.valid;
    assign eval_idx    = out_q.idx;
    assign spike_valid = out_q.spike;
    assign spike_idx   = out_q.idx;
    assign eval_vmem   = out_q.vmem;
    assign eval_theta  = out_q.theta;

endmodule

// File: rtl/lif_neuron_unit_chk.sv
module lif_neuron_unit_chk #(
    parameter int NUM_VN = 8,
    parameter int VREST  = -6500,
    localparam int IW    = (NUM_VN > 1) ? $clog2(NUM_VN) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eval_valid,
    input logic [IW-1:0] eval_idx,
    input logic          spike_valid,
    input logic [IW-1:0] spike_idx,
    input logic [15:0]   eval_vmem,
    input logic [15:0]   eval_theta
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_VN - 1);

    // R1: nothing is signalled outside a result cycle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_valid |-> (!spike_valid && eval_vmem == 16'd0 && eval_theta == 16'd0));

    // R2: a step opens at neuron zero
    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eval_valid) |-> (eval_idx == '0));

    // R2: slots follow each other without gaps until the last index
    p_slot_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid && eval_idx != LAST_IDX) |=>
            (eval_valid && eval_idx == IW'($past(eval_idx) + 1'b1)));

    // R5: a spike carries the index of the slot it occurs in
    p_spike_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spike_valid |-> (eval_valid && spike_idx == eval_idx));

    // R5: a firing neuron is reported at rest
    p_spike_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spike_valid |-> (eval_vmem == 16'(VREST)));

    // R6: theta starts at zero and only grows by a non-negative step or shrinks toward zero
    p_theta_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid |-> !eval_theta[15]);

endmodule

bind lif_neuron_unit lif_neuron_unit_chk #(
    .NUM_VN (NUM_VN),
    .VREST  (VREST)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_valid  (eval_valid),
    .eval_idx    (eval_idx),
    .spike_valid (spike_valid),
    .spike_idx   (spike_idx),
    .eval_vmem   (eval_vmem),
    .eval_theta  (eval_theta)
);

// File: tb/test_lif_neuron_unit.sv
module test_lif_neuron_unit;

    localparam int NV    = 8;
    localparam int VR    = -6500;
    localparam int VT    = -5000;
    localparam int KM    = 1;
    localparam int CS    = 2;
    localparam int TM    = 3;
    localparam int GES   = 2;
    localparam int GIS   = 1;
    localparam int DT    = 200;
    localparam int TS    = 2;
    localparam int DEC   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_start = 1'b0;
    logic [7:0]  homeo_en = 8'hFF;
    logic        syn_valid = 1'b0;
    logic [2:0]  syn_idx = '0;
    logic        syn_inh = 1'b0;
    logic [15:0] syn_weight = '0;
    logic        spike_valid;
    logic [2:0]  spike_idx;
    logic        eval_valid;
    logic [2:0]  eval_idx;
    logic signed [15:0] eval_vmem;
    logic signed [15:0] eval_theta;

    lif_neuron_unit #(
        .NUM_VN (NV), .VREST (VR), .VTH (VT), .K_MUL (KM), .CUR_SHIFT (CS),
        .TAU_M_SHIFT (TM), .GEX_SHIFT (GES), .GIH_SHIFT (GIS), .DTHETA (DT),
        .THETA_SHIFT (TS), .DECIM (DEC)
    ) i_lif_neuron_unit (
        .clk (clk), .rst_n (rst_n), .step_start (step_start), .homeo_en (homeo_en),
        .syn_valid (syn_valid), .syn_idx (syn_idx), .syn_inh (syn_inh),
        .syn_weight (syn_weight), .spike_valid (spike_valid), .spike_idx (spike_idx),
        .eval_valid (eval_valid), .eval_idx (eval_idx), .eval_vmem (eval_vmem),
        .eval_theta (eval_theta)
    );

    always #2ns clk = ~clk;

    int v_m [NV];
    int ge_m [NV];
    int gi_m [NV];
    int th_m [NV];
    int step_m = 0;
    int nchk = 0;
    int nerr = 0;
    int spikes_seen = 0;
    bit done = 1'b0;

    function automatic int sat(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_ev(input int idx, input bit inh, input int w);
        @(negedge clk);
        syn_valid  = 1'b1;
        syn_idx    = 3'(idx);
        syn_inh    = inh;
        syn_weight = 16'(w);
        @(negedge clk);
        syn_valid  = 1'b0;
        if (inh) gi_m[idx] = sat(longint'(gi_m[idx]) + w);
        else     ge_m[idx] = sat(longint'(ge_m[idx]) + w);
    endtask

    // One full time step; optional same-slot event and a stray start pulse.
    task automatic run_step(input int ev_slot, input int ev_w, input bit ev_inh,
                            input bit stray);
        int  ev [NV];
        int  et [NV];
        bit  es [NV];
        bit  dec;
        dec = ((step_m % DEC) == DEC - 1);
        for (int n = 0; n < NV; n++) begin
            int vi;
            int th;
            bit en;
            en = homeo_en[n];
            vi = sat(longint'(v_m[n]) + ((VR - v_m[n]) >>> TM)
                     + ((KM * (ge_m[n] + gi_m[n])) >>> CS));
            th = th_m[n];
            if (dec && en) th = th - (th >>> TS);
            es[n] = (vi >= sat(longint'(VT) + th));
            if (es[n]) begin
                vi = VR;
                spikes_seen++;
                if (en) th = sat(longint'(th) + DT);
            end
            v_m[n]  = vi;
            th_m[n] = th;
            ge_m[n] = ge_m[n] - (ge_m[n] >>> GES);
            gi_m[n] = gi_m[n] - (gi_m[n] >>> GIS);
            ev[n] = vi;
            et[n] = th;
        end
        step_m++;
        @(negedge clk);
        step_start = 1'b1;
        @(posedge clk);
        for (int j = 0; j < NV; j++) begin
            @(negedge clk);
            step_start = stray && (j == 3);
            syn_valid  = (j == ev_slot);
            if (j == ev_slot) begin
                syn_idx    = 3'(j);
                syn_inh    = ev_inh;
                syn_weight = 16'(ev_w);
            end
            @(posedge clk);
            #1ns;
            chk("R2 eval_valid", int'(eval_valid), 1);
            chk("R2 eval_idx", int'(eval_idx), j);
            chk("R3 R4 R9 R10 vmem", int'(eval_vmem), ev[j]);
            chk("R6 R7 R8 theta", int'(eval_theta), et[j]);
            chk("R5 spike_valid", int'(spike_valid), int'(es[j]));
            if (es[j]) chk("R5 spike_idx", int'(spike_idx), j);
        end
        @(negedge clk);
        step_start = 1'b0;
        syn_valid  = 1'b0;
        @(posedge clk);
        #1ns;
        chk("R2 idle after step", int'(eval_valid), 0);
        chk("R1 no spike when idle", int'(spike_valid), 0);
        if (ev_slot >= 0) begin
            if (ev_inh) gi_m[ev_slot] = sat(longint'(gi_m[ev_slot]) + ev_w);
            else        ge_m[ev_slot] = sat(longint'(ge_m[ev_slot]) + ev_w);
        end
    endtask

    task automatic pattern_events(input int s);
        for (int n = 0; n < NV; n++) begin
            if (n == 7) send_ev(n, 1'b1, -(50 + (s * 17) % 200));
            else        send_ev(n, 1'b0, 100 + ((n * 53 + s * 29) % 350));
        end
        if (s % 5 == 0) send_ev(2, 1'b1, -300);
    endtask

    initial begin
        for (int n = 0; n < NV; n++) begin
            v_m[n] = VR; ge_m[n] = 0; gi_m[n] = 0; th_m[n] = 0;
        end
        repeat (3) @(posedge clk);
        #1ns;
        chk("R1 reset eval_valid", int'(eval_valid), 0);
        chk("R1 reset spike_valid", int'(spike_valid), 0);
        chk("R1 reset vmem", int'(eval_vmem), 0);
        chk("R1 reset theta", int'(eval_theta), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: a step with no input leaves every neuron at rest
        run_step(-1, 0, 1'b0, 1'b0);
        // Mixed excitatory and inhibitory drive with homeostasis on everywhere
        for (int s = 0; s < 40; s++) begin
            pattern_events(s);
            if (s == 10)      run_step(4, 500, 1'b0, 1'b1);
            else if (s == 20) run_step(7, -400, 1'b1, 1'b0);
            else              run_step(-1, 0, 1'b0, 1'b0);
        end
        chk("R5 spikes occurred", int'(spikes_seen > 0), 1);
        // R9: drive conductances and potential into both rails
        for (int s = 0; s < 6; s++) begin
            send_ev(5, 1'b0, 32767);
            send_ev(5, 1'b0, 32767);
            send_ev(6, 1'b1, -32768);
            send_ev(6, 1'b1, -32768);
            run_step(-1, 0, 1'b0, 1'b0);
        end
        // R8: homeostasis off for the upper half
        homeo_en = 8'h0F;
        for (int s = 0; s < 12; s++) begin
            pattern_events(s + 3);
            run_step((s == 5) ? 6 : -1, 900, 1'b0, s == 7);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule